// File: doc/BRIEF.md
# Software-Triggered Interrupt Hub

This block lets software running anywhere in the system raise interrupts toward a group of processor cores with nothing more than one register write. Every core owns a bank of maskable virtual interrupt bits (eight per core, three cores by default) and one virtual non-maskable interrupt. A maskable bit, once raised, stays pending until software clears it. A non-maskable request produces a one-cycle pulse on the core's NMI line and cannot be masked.

The hub merges the virtual interrupts with a set of external interrupt inputs. It drives one level interrupt line and one NMI line per core. It also consolidates selected sources onto two device-level outputs, a shared interrupt output and a shared NMI output, under the control of routing enable bits.

All control goes through a plain write/read register bus. Reads return data combinationally from the addressed register.

Top module: `soft_irq_hub`

## Requirements
- R1: After reset every output is low and every register address reads zero.
- R2: A write to core c's trigger register (address c, c < NUM_CORES) sets the status bits given in write bits [7:0] on the next clock edge. Those bits stay set until cleared. Reading address c returns core c's status in bits [7:0].
- R3: Write bits [15:8] of the trigger register clear the corresponding status bits (write-one-to-clear). If one write both sets and clears the same bit, the bit ends up set.
- R4: Writing a 1 to bit 16 of core c's trigger register makes core_nmi[c] high for exactly one cycle, starting at the clock edge that takes the write. The mask has no effect on this pulse, and the status bits do not change.
- R5: core_irq[c] is high while any status bit of core c is pending with its mask bit set. The mask register is at address 4, and bit c*8+i enables bit i of core c. A masked bit still reads back as pending in the status.
- R6: External input ext_irq[e] drives core_irq[c] when bit c*NUM_EXT+e of the external enable register (address 6) is set.
- R7: dev_irq_out is high when a routed source is active. Routing register (address 5) bit c routes core c's masked virtual line. Bit 2*NUM_CORES+e routes ext_irq[e].
- R8: dev_nmi_out repeats core c's NMI pulse in the same cycle when routing bit NUM_CORES+c is set. It stays low for NMI pulses from cores whose routing bit is clear.
- R9: Address 7 reads the masked pending vector (status AND mask). Unused addresses read zero, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ext_irq | input | NUM_EXT | External interrupt sources, level |
| core_irq | output | NUM_CORES | Maskable interrupt line per core |
| core_nmi | output | NUM_CORES | Non-maskable pulse per core |
| dev_irq_out | output | 1 | Device-level consolidated interrupt |
| dev_nmi_out | output | 1 | Device-level consolidated NMI |

## Verification
A corrupted pending bit surfaces at the ports in one of three ways. It can appear in the status read-back of the same core at the next clock edge. It can raise or drop core_irq once that bit is unmasked, or dev_irq_out once the core line is routed. A stray or stretched NMI pulse is visible on core_nmi and dev_nmi_out in the cycle it happens, so the bench samples those lines in the cycle after each write. Mask, enable and routing faults are exposed by walking single bits through each register and watching which line responds.

// File: rtl/sih_pkg.sv
package sih_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int SET_LSB = 0;
  localparam int CLR_LSB = 8;
  localparam int NMI_BIT = 16;

  localparam logic [ADDR_W-1:0] A_MASK  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ROUTE = 4'd5;
  localparam logic [ADDR_W-1:0] A_EXTEN = 4'd6;
  localparam logic [ADDR_W-1:0] A_PEND  = 4'd7;

  // set wins over clear on the same bit
  function automatic logic [7:0] next_status(logic [7:0] cur, logic [7:0] set_b, logic [7:0] clr_b);
    return (cur & ~clr_b) | set_b;
  endfunction

  function automatic logic any_enabled(logic [31:0] src, logic [31:0] en);
    return |(src & en);
  endfunction
endpackage

// File: rtl/sih_core_slice.sv
module sih_core_slice
  import sih_pkg::*;
#(
  parameter int VIRQ = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [VIRQ-1:0]   status,
  output logic [VIRQ-1:0]   set_req,
  output logic [VIRQ-1:0]   clr_req,
  output logic              nmi_req,
  output logic              nmi_pulse
);
  logic [7:0] cur8, set8, clr8, nxt8;

  assign set_req = hit ? wdata[SET_LSB +: VIRQ] : '0;
  assign clr_req = hit ? wdata[CLR_LSB +: VIRQ] : '0;
  assign nmi_req = hit & wdata[NMI_BIT];

  always_comb begin
    cur8 = '0;
    set8 = '0;
    clr8 = '0;
    cur8[VIRQ-1:0] = status;
    set8[VIRQ-1:0] = set_req;
    clr8[VIRQ-1:0] = clr_req;
    nxt8 = next_status(cur8, set8, clr8);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= '0;
      nmi_pulse <= 1'b0;
    end else begin
      status    <= nxt8[VIRQ-1:0];
      nmi_pulse <= nmi_req;
    end
  end
endmodule

// File: rtl/sih_cfg_regs.sv
module sih_cfg_regs
  import sih_pkg::*;
#(
  parameter int VW = 24,
  parameter int RW = 10,
  parameter int EW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [VW-1:0]     mask,
  output logic [RW-1:0]     route,
  output logic [EW-1:0]     exten
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '0;
      route <= '0;
      exten <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MASK)  mask  <= bus_wdata[VW-1:0];
      if (bus_addr == A_ROUTE) route <= bus_wdata[RW-1:0];
      if (bus_addr == A_EXTEN) exten <= bus_wdata[EW-1:0];
    end
  end
endmodule

// File: rtl/sih_consolidate.sv
module sih_consolidate
  import sih_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int VIRQ      = 8,
  parameter int NUM_EXT   = 4,
  localparam int VW = NUM_CORES * VIRQ,
  localparam int RW = 2 * NUM_CORES + NUM_EXT,
  localparam int EW = NUM_CORES * NUM_EXT
) (
  input  logic [VW-1:0]        status_all,
  input  logic [VW-1:0]        mask,
  input  logic [EW-1:0]        exten,
  input  logic [RW-1:0]        route,
  input  logic [NUM_EXT-1:0]   ext_irq,
  input  logic [NUM_CORES-1:0] nmi_pulse,
  output logic [NUM_CORES-1:0] vline,
  output logic [NUM_CORES-1:0] core_irq,
  output logic                 dev_irq_out,
  output logic                 dev_nmi_out
);
  logic [31:0] ext_w;
  assign ext_w = 32'(ext_irq);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [31:0] st_w, mk_w, en_w;
    assign st_w = 32'(status_all[c*VIRQ +: VIRQ]);
    assign mk_w = 32'(mask[c*VIRQ +: VIRQ]);
    assign en_w = 32'(exten[c*NUM_EXT +: NUM_EXT]);
    assign vline[c]    = any_enabled(st_w, mk_w);
    assign core_irq[c] = vline[c] | any_enabled(ext_w, en_w);
  end

  assign dev_irq_out = any_enabled(32'(vline), 32'(route[NUM_CORES-1:0]))
                     | any_enabled(ext_w, 32'(route[2*NUM_CORES +: NUM_EXT]));
  assign dev_nmi_out = any_enabled(32'(nmi_pulse), 32'(route[NUM_CORES +: NUM_CORES]));
endmodule

// File: rtl/soft_irq_hub.sv
module soft_irq_hub
  import sih_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int VIRQ      = 8,
  parameter int NUM_EXT   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [3:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_EXT-1:0]   ext_irq,
  output logic [NUM_CORES-1:0] core_irq,
  output logic [NUM_CORES-1:0] core_nmi,
  output logic                 dev_irq_out,
  output logic                 dev_nmi_out
);
  localparam int VW = NUM_CORES * VIRQ;
  localparam int RW = 2 * NUM_CORES + NUM_EXT;
  localparam int EW = NUM_CORES * NUM_EXT;

  logic [VW-1:0]        status_all, set_vec, clr_vec, mask;
  logic [RW-1:0]        route;
  logic [EW-1:0]        exten;
  logic [NUM_CORES-1:0] gen_hit, nmi_req, vline;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slice
    assign gen_hit[c] = bus_wr && (bus_addr == ADDR_W'(c));
    sih_core_slice #(.VIRQ(VIRQ)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (gen_hit[c]),
      .wdata    (bus_wdata),
      .status   (status_all[c*VIRQ +: VIRQ]),
      .set_req  (set_vec[c*VIRQ +: VIRQ]),
      .clr_req  (clr_vec[c*VIRQ +: VIRQ]),
      .nmi_req  (nmi_req[c]),
      .nmi_pulse(core_nmi[c])
    );
  end

  sih_cfg_regs #(.VW(VW), .RW(RW), .EW(EW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .mask     (mask),
    .route    (route),
    .exten    (exten)
  );

  sih_consolidate #(.NUM_CORES(NUM_CORES), .VIRQ(VIRQ), .NUM_EXT(NUM_EXT)) u_cons (
    .status_all (status_all),
    .mask       (mask),
    .exten      (exten),
    .route      (route),
    .ext_irq    (ext_irq),
    .nmi_pulse  (core_nmi),
    .vline      (vline),
    .core_irq   (core_irq),
    .dev_irq_out(dev_irq_out),
    .dev_nmi_out(dev_nmi_out)
  );

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CORES; c++)
      if (bus_addr == ADDR_W'(c)) bus_rdata[VIRQ-1:0] = status_all[c*VIRQ +: VIRQ];
    case (bus_addr)
      A_MASK:  bus_rdata[VW-1:0] = mask;
      A_ROUTE: bus_rdata[RW-1:0] = route;
      A_EXTEN: bus_rdata[EW-1:0] = exten;
      A_PEND:  bus_rdata[VW-1:0] = status_all & mask;
      default: ;
    endcase
  end
endmodule

// File: rtl/sih_checks.sv
module sih_checks #(
  parameter int NUM_CORES = 3,
  parameter int VIRQ      = 8,
  parameter int NUM_EXT   = 4,
  localparam int VW = NUM_CORES * VIRQ,
  localparam int EW = NUM_CORES * NUM_EXT
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [VW-1:0]        set_vec,
  input logic [VW-1:0]        clr_vec,
  input logic [VW-1:0]        status_all,
  input logic [VW-1:0]        mask,
  input logic [EW-1:0]        exten,
  input logic [NUM_CORES-1:0] nmi_req,
  input logic [NUM_CORES-1:0] core_nmi,
  input logic [NUM_CORES-1:0] core_irq,
  input logic                 dev_nmi_out
);
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_all & $past(set_vec)) == $past(set_vec)));

  assert_no_spurious_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0) |=> ((status_all & ~$past(status_all)) == '0));

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((status_all & $past(clr_vec & ~set_vec)) == '0));

  assert_nmi_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req == '0) |=> (core_nmi == '0));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0 && exten == '0) |-> (core_irq == '0));

  assert_dev_nmi_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_nmi_out |-> (core_nmi != '0));
endmodule

bind soft_irq_hub sih_checks #(.NUM_CORES(NUM_CORES), .VIRQ(VIRQ), .NUM_EXT(NUM_EXT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .set_vec    (set_vec),
  .clr_vec    (clr_vec),
  .status_all (status_all),
  .mask       (mask),
  .exten      (exten),
  .nmi_req    (nmi_req),
  .core_nmi   (core_nmi),
  .core_irq   (core_irq),
  .dev_nmi_out(dev_nmi_out)
);

// File: tb/soft_irq_hub_test.sv
`timescale 1ns/1ps
module soft_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  ext_irq = '0;
  logic [2:0]  core_irq, core_nmi;
  logic        dev_irq_out, dev_nmi_out;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  soft_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_irq(ext_irq),
    .core_irq(core_irq), .core_nmi(core_nmi),
    .dev_irq_out(dev_irq_out), .dev_nmi_out(dev_nmi_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 core_irq", 32'(core_irq), 0);
    chk("R1 core_nmi", 32'(core_nmi), 0);
    chk("R1 dev outs", {30'b0, dev_irq_out, dev_nmi_out}, 0);
    for (int a = 0; a < 8; a++) rd_chk("R1 reg", 4'(a), 0);
  endtask

  task automatic t_set_hold;
    wr(4'd1, 32'h05);
    rd_chk("R2 status set", 4'd1, 32'h05);
    chk("R5 masked line low", 32'(core_irq), 0);
    repeat (4) @(negedge clk);
    rd_chk("R2 status held", 4'd1, 32'h05);
  endtask

  task automatic t_mask;
    wr(4'd4, 32'h400);
    chk("R5 unmasked line", 32'(core_irq), 32'b010);
    rd_chk("R9 pending view", 4'd7, 32'h400);
    rd_chk("R5 masked bit still pending", 4'd1, 32'h05);
  endtask

  task automatic t_clear;
    wr(4'd1, 32'h0400);
    rd_chk("R3 w1c", 4'd1, 32'h01);
    chk("R3 line drops", 32'(core_irq), 0);
    wr(4'd1, 32'h8080);
    rd_chk("R3 set wins", 4'd1, 32'h81);
    wr(4'd0, 32'h03);
    rd_chk("R2 core0", 4'd0, 32'h03);
    rd_chk("R2 core1 untouched", 4'd1, 32'h81);
  endtask

  task automatic t_nmi;
    wr(4'd2, 32'h10000);
    chk("R4 nmi pulse", 32'(core_nmi), 32'b100);
    chk("R8 unrouted dev nmi", 32'(dev_nmi_out), 0);
    @(negedge clk);
    chk("R4 nmi one cycle", 32'(core_nmi), 0);
    rd_chk("R4 status untouched", 4'd2, 0);
    wr(4'd5, 32'h20);
    wr(4'd2, 32'h10000);
    chk("R8 routed dev nmi", 32'(dev_nmi_out), 1);
    @(negedge clk);
    chk("R8 dev nmi ends", 32'(dev_nmi_out), 0);
    wr(4'd0, 32'h10000);
    chk("R4 core0 nmi", 32'(core_nmi), 32'b001);
    chk("R8 other core unrouted", 32'(dev_nmi_out), 0);
  endtask

  task automatic t_ext;
    ext_irq = 4'b0010;
    #1;
    chk("R6 ext disabled", 32'(core_irq), 0);
    wr(4'd6, 32'h2);
    chk("R6 ext to core0", 32'(core_irq), 32'b001);
    wr(4'd6, 32'h202);
    chk("R6 ext to core0 and core2", 32'(core_irq), 32'b101);
    chk("R7 ext unrouted", 32'(dev_irq_out), 0);
  endtask

  task automatic t_route;
    wr(4'd5, 32'hA0);
    chk("R7 ext routed", 32'(dev_irq_out), 1);
    ext_irq = '0;
    #1;
    chk("R7 ext released", 32'(dev_irq_out), 0);
    chk("R6 lines released", 32'(core_irq), 0);
    wr(4'd4, 32'h100);
    chk("R5 core1 line", 32'(core_irq), 32'b010);
    chk("R7 core line unrouted", 32'(dev_irq_out), 0);
    wr(4'd5, 32'h2);
    chk("R7 core line routed", 32'(dev_irq_out), 1);
    wr(4'd1, 32'h100);
    chk("R3 clear drops line", 32'(core_irq), 0);
    chk("R7 dev drops", 32'(dev_irq_out), 0);
  endtask

  task automatic t_unmapped;
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    chk("R9 no line change", 32'(core_irq), 0);
    chk("R9 no nmi", 32'(core_nmi), 0);
    rd_chk("R9 core0", 4'd0, 32'h03);
    rd_chk("R9 core1", 4'd1, 32'h80);
    rd_chk("R9 core2", 4'd2, 0);
    rd_chk("R9 mask", 4'd4, 32'h100);
    rd_chk("R9 route", 4'd5, 32'h2);
    rd_chk("R9 exten", 4'd6, 32'h202);
    rd_chk("R9 unused 3", 4'd3, 0);
    rd_chk("R9 unused 12", 4'd12, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_hold();
    t_mask();
    t_clear();
    t_nmi();
    t_ext();
    t_route();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule